// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface. It takes the memory from power-on to a state where normal traffic can start. After reset it drives a quiet bus for a timed pause: every command is NOP, clock enable is high and all data-mask lines are high. It then closes every bank with one precharge, issues a set number of auto-refresh commands spaced by the row cycle time, and writes the mode register with a word fixed at build time. Each gap between commands is a whole number of clock cycles. The block works out each gap from a timing in nanoseconds and the clock period, and rounds it up.

When the wait after the mode write has run out, `done_o` goes high and stays high. From then on the command bus idles at NOP, and the block's outputs can be handed to the normal access scheduler. A synchronous `restart_i` begins the whole sequence again from the pause, at any point. The timings, refresh count, bus widths and mode word are parameters.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_ni` is low, and in every pause cycle, the outputs are as follows: the command is NOP ({cs_n,ras_n,cas_n,we_n}=0111), `cke_o`=1, every `dqm_o` bit is 1, `addr_o`=0 and `done_o`=0.
- R2: The pause lasts ceil(PAUSE_NS/period) cycles, which is 10000 at the defaults. The first cycle after reset release is pause cycle 0, so the first command other than NOP appears in cycle 10000.
- R3: The first command is a precharge of all banks: code 0010, with `addr_o` bit 10 set (0x400) and `ba_o`=0.
- R4: The first auto-refresh (code 0001) comes exactly ceil(tRP/period) cycles after the precharge. This is 2 cycles for 21 ns at 20 ns.
- R5: Exactly NUM_REFRESH (8) auto-refresh commands are issued. Two consecutive refreshes, and the last refresh and the mode write, are exactly ceil(tRC/period) cycles apart. This is 4 cycles for 70 ns.
- R6: The mode write uses code 0000, with `addr_o` = MODE_WORD (default 0x032) and `ba_o`=0.
- R7: `done_o` rises exactly ceil(tRCS/period) cycles after the mode write (1 cycle for 14 ns). Every cycle that carries no command is NOP. Once `done_o` is high it stays high, with NOP on the bus, until a restart.
- R8: `cke_o` is always 1. `dqm_o` is all ones until `done_o` rises and all zeros after it.
- R9: If `restart_i` is high at a clock edge, the next cycle is pause cycle 0: the R1 outputs hold and `done_o` is 0. The full sequence then replays with the R2 to R7 timing, counted from that cycle. This holds whether the restart comes during the sequence or after it has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart of the whole sequence |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W (12) | Address bus: all-bank flag on precharge, mode word on mode write |
| ba_o | output | BA_W (1) | Bank address |
| dqm_o | output | DQM_W (2) | Data mask, one bit per byte lane |
| done_o | output | 1 | Initialization complete |

## Verification
The hardest case to reach is a restart that lands partway through the refresh train. At that point the refresh counter and the wait timer both hold values that are neither their reset values nor their final values. Reaching it means running a full pause of ten thousand cycles and then stopping at a chosen refresh. The stimulus first runs one whole sequence. It then restarts after completion and lets the replay run to just past the third refresh. There it asserts `restart_i` again and checks every cycle of the third replay against a cycle-exact expected schedule. Any counter state left over from the interrupted replay would show up as a shifted or missing refresh.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_DONE
  } init_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  // round a delay up to whole clock cycles, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_W'(RESET_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // once expired, the count stays at zero until it is reloaded
  a_r2_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BA_W        = 1,
  parameter int unsigned DQM_W       = 2,
  parameter int unsigned ALL_BANK_BIT = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
  input  init_state_e       state_i,
  input  logic              issue_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [DQM_W-1:0]  dqm_o
);

  sdram_cmd_e cmd;

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    if (issue_i) begin
      unique case (state_i)
        ST_PRE: begin
          cmd                  = CMD_PRE;
          addr_o[ALL_BANK_BIT] = 1'b1;
        end
        ST_REF: cmd = CMD_REF;
        ST_MRS: begin
          cmd    = CMD_MRS;
          addr_o = MODE_WORD;
        end
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign ba_o  = '0;
  assign cke_o = 1'b1;
  // masks stay raised until the sequence hands over the bus
  assign dqm_o = {DQM_W{state_i != ST_DONE}};

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned PAUSE_NS      = 200000,
  parameter int unsigned T_RP_NS       = 21,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_RCS_NS      = 14,
  parameter int unsigned NUM_REFRESH   = 8,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned BA_W          = 1,
  parameter int unsigned DQM_W         = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              done_o
);

  localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PERIOD_PS);
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_PS);
  localparam int unsigned RCS_CYC   = ns_to_cyc(T_RCS_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC   = max2(max2(PAUSE_CYC, RP_CYC), max2(RC_CYC, RCS_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
  localparam int unsigned REF_W     = (NUM_REFRESH > 1) ? $clog2(NUM_REFRESH) : 1;

  init_state_e      state_q, state_d;
  logic             issue_q, issue_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  sdram_init_timer #(
    .CNT_W    (CNT_W),
    .RESET_VAL(PAUSE_CYC - 1)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_expired)
  );

  // each command state lasts its full gap; the command occupies its first cycle
  always_comb begin
    state_d  = state_q;
    issue_d  = 1'b0;
    ref_d    = ref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (restart_i) begin
      state_d  = ST_PAUSE;
      ref_d    = '0;
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(PAUSE_CYC - 1);
    end else if (tmr_expired) begin
      unique case (state_q)
        ST_PAUSE: begin
          state_d  = ST_PRE;
          issue_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RP_CYC - 1);
        end
        ST_PRE: begin
          state_d  = ST_REF;
          issue_d  = 1'b1;
          ref_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RC_CYC - 1);
        end
        ST_REF: begin
          issue_d  = 1'b1;
          tmr_load = 1'b1;
          if (ref_q == REF_W'(NUM_REFRESH - 1)) begin
            state_d = ST_MRS;
            tmr_val = CNT_W'(RCS_CYC - 1);
          end else begin
            ref_d   = ref_q + 1'b1;
            tmr_val = CNT_W'(RC_CYC - 1);
          end
        end
        ST_MRS:  state_d = ST_DONE;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      issue_q <= 1'b0;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      issue_q <= issue_d;
      ref_q   <= ref_d;
    end
  end

  sdram_init_cmd_enc #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .DQM_W    (DQM_W),
    .MODE_WORD(MODE_WORD)
  ) u_enc (
    .state_i(state_q),
    .issue_i(issue_q),
    .cke_o  (cke_o),
    .cs_n_o (cs_n_o),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o),
    .we_n_o (we_n_o),
    .addr_o (addr_o),
    .ba_o   (ba_o),
    .dqm_o  (dqm_o)
  );

  assign done_o = (state_q == ST_DONE);

  logic is_nop, is_pre, is_ref, is_mrs;
  assign is_nop = !cs_n_o && !ras_n_o == 1'b0 && !cas_n_o == 1'b0 && !we_n_o == 1'b0;
  assign is_pre = !cs_n_o && !ras_n_o && cas_n_o && !we_n_o;
  assign is_ref = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o;
  assign is_mrs = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;

  a_r1_pause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE) |-> (is_nop && cke_o && (&dqm_o) && !done_o));

  a_r3_pre_after_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE && tmr_expired && !restart_i) |=> (is_pre && addr_o[10]));

  a_r6_mrs_after_last_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> (ref_q == REF_W'(NUM_REFRESH - 1) && addr_o == MODE_WORD));

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> (done_o && is_nop && dqm_o == '0));

  a_r9_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!done_o && is_nop && (&dqm_o)));

  if (RC_CYC > 1) begin : g_rc_gap_chk
    a_r5_ref_followed_by_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_ref && !restart_i) |=> is_nop);
  end

endmodule

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

  localparam int P   = 10000;          // pause cycles
  localparam int RP  = 2;              // ceil(21/20)
  localparam int RC  = 4;              // ceil(70/20)
  localparam int RCS = 1;              // ceil(14/20)
  localparam int NREF = 8;
  localparam int M   = P + RP + NREF * RC;   // mode write cycle
  localparam int D   = M + RCS;              // done rise cycle
  localparam logic [11:0] MODE = 12'h032;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic restart_i = 1'b0;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [11:0] addr_o;
  logic [0:0]  ba_o;
  logic [1:0]  dqm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  sdram_init_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .addr_o(addr_o), .ba_o(ba_o), .dqm_o(dqm_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int t);
    if (t == P) return PRE;
    for (int k = 0; k < NREF; k++) if (t == P + RP + k * RC) return REF;
    if (t == M) return MRS;
    return NOP;
  endfunction

  function automatic string req_of(input int t);
    if (t == P) return "R3";
    if (t == P + RP) return "R4";
    if (t > P + RP && t <= M - RC) return "R5";
    if (t == M) return "R6";
    if (t > M - RC && t < M) return "R5";
    return "R7";
  endfunction

  // walks cycles 0..last_t from pause cycle 0, comparing against the schedule
  task automatic run_seq(input int last_t);
    int pause_bad = 0;
    for (int t = 0; t <= last_t; t++) begin
      logic [3:0] c;
      logic [3:0] ec;
      c = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
      if (t < P) begin
        if (c != NOP || dqm_o != 2'b11 || cke_o !== 1'b1 || done_o !== 1'b0 || addr_o != 12'h0)
          pause_bad++;
        if (t == P - 1) chk(pause_bad == 0, "R2", "pause cycles disturbed", pause_bad, 0);
      end else begin
        ec = exp_cmd(t);
        chk(c == ec, req_of(t), $sformatf("command at cycle %0d", t), c, ec);
        if (ec == PRE) chk(addr_o[10] && ba_o == 1'b0, "R3", "all-bank address", addr_o, 12'h400);
        if (ec == MRS) chk(addr_o == MODE && ba_o == 1'b0, "R6", "mode word", addr_o, MODE);
        chk(done_o == (t >= D), "R7", $sformatf("done at cycle %0d", t), done_o, t >= D);
        chk(dqm_o == ((t >= D) ? 2'b00 : 2'b11), "R8", $sformatf("dqm at cycle %0d", t),
            dqm_o, (t >= D) ? 0 : 3);
        chk(cke_o === 1'b1, "R8", "cke", cke_o, 1);
      end
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic pulse_restart();
    restart_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    restart_i = 1'b0;
    chk(!done_o && dqm_o == 2'b11 && {cs_n_o, ras_n_o, cas_n_o, we_n_o} == NOP,
        "R9", "outputs after restart", {done_o, dqm_o, cs_n_o, ras_n_o, cas_n_o, we_n_o}, 7'h37);
  endtask

  task automatic test_reset_state();
    repeat (3) @(negedge clk_i);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == NOP, "R1", "command in reset", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, NOP);
    chk(cke_o === 1'b1 && dqm_o == 2'b11, "R1", "cke/dqm in reset", {cke_o, dqm_o}, 7);
    chk(done_o === 1'b0 && addr_o == 12'h0, "R1", "done/addr in reset", {done_o, addr_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic test_full_sequence();
    run_seq(D + 4);
  endtask

  task automatic test_done_hold();
    int bad = 0;
    for (int i = 0; i < 30; i++) begin
      if (!done_o || dqm_o != 2'b00 || {cs_n_o, ras_n_o, cas_n_o, we_n_o} != NOP) bad++;
      @(negedge clk_i);
    end
    chk(bad == 0, "R7", "done held with NOP", bad, 0);
  endtask

  task automatic test_restart_after_done();
    pulse_restart();
    run_seq(P + RP + 2 * RC + 1);
  endtask

  task automatic test_restart_mid_refresh();
    pulse_restart();
    run_seq(D + 2);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset_state();
    test_full_sequence();
    test_done_hold();
    test_restart_after_done();
    test_restart_mid_refresh();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule